// File: doc/BRIEF.md
# Analog Frame Window Capture

This block takes the stream of 12-bit ADC samples read back from one analog front-end chip, one sample per readout clock, and turns each trigger into a fixed-length, non-zero-suppressed window in a channel buffer. Each chip frame is a 12-sample digital header followed by 128 channel samples. An event holds one to three consecutive frames, with ten baseline samples kept on each side of them. With three frames the window is 440 samples. With one frame it is 160.

After a trigger the block searches the stream for the start of a header. A sample counts as a digital one when it is above a programmable threshold, and a header is accepted once three ones arrive back to back. The incoming samples pass through a short delay line. Because of it, the baseline samples that came before the header can still be written once the header is recognised. Each sample is written to its own address, in arrival order, in a 16-bit slot whose top four bits are zero. If no header shows up before a programmable timeout, the block raises a sticky sync-error flag and still writes a full window, filled with zeros. A trigger that arrives during a capture is dropped and counted. A one-cycle event-done pulse follows the last write.

Top module: `frame_window_capture`

## Requirements
- R1: The window length is 10 + n*140 + 10 samples. n is `frames_cfg` taken at the accepted trigger, with 0 read as 1 and values above 3 read as 3. Addresses 0 to length-1 are written in increasing order, one per cycle, with no gaps.
- R2: A sample is a digital one only when it is strictly greater than `thresh`. The search starts in the cycle after the trigger is accepted. The header is found on the first search cycle whose sample, and the two samples of the search cycles just before it, are all ones.
- R3: Address 10 holds the first header sample. Address a holds the sample presented a-10 cycles after that first header sample, so addresses 0 to 9 hold the ten samples before it. Bits 15:12 of `wr_data` are always zero.
- R4: The write of address 0 appears on the port in the cycle after the third header sample is presented.
- R5: Search cycles are counted from 0, and T is `timeout_cfg`. If the header is not found by search cycle T-1, the window starts at that cycle. Address 0 then appears in the next cycle, every data word is zero, and `sync_err` is set. A header found on cycle T-1 itself is still accepted.
- R6: Once set, `sync_err` stays set until reset.
- R7: A trigger that arrives while a window is being searched for or written is ignored and leaves that window unchanged. Each such trigger adds one to `ovr_cnt`, which stops at 255.
- R8: `event_done` is high for exactly one cycle, in the cycle after the write of the last address is shown.
- R9: After reset, `wr_en`, `event_done` and `sync_err` are 0 and `ovr_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | 12 | ADC sample for this cycle |
| trig | input | 1 | Trigger strobe |
| frames_cfg | input | 2 | Frames per event (0 read as 1) |
| thresh | input | 12 | Digital-one threshold for header decoding |
| timeout_cfg | input | 8 | Header search timeout in cycles |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 9 | Buffer write address within the window |
| wr_data | output | 16 | Sample slot, upper four bits zero |
| event_done | output | 1 | One-cycle pulse after the last write |
| sync_err | output | 1 | Sticky header-timeout flag |
| ovr_cnt | output | 8 | Saturating count of ignored triggers |

## Verification
If the search run counter or the delay-line tap is off by even one stage, every written word shifts by one address against the stream. This shows in the very first write of the window, and the address-0 write moves by a cycle. A wrong latched window length or address counter changes the write count, and it moves the done pulse by exactly that many cycles when the event ends. A broken timeout comparison or pad select shows up on the first padded write, as a start one cycle off or nonzero data. Busy-state mistakes show as an extra window or as a wrong `ovr_cnt` as soon as the dropped trigger is registered.

// File: rtl/afw_pkg.sv
package afw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEARCH = 2'd1,
      ST_CAPT   = 2'd2
   } afw_state_e;

   function automatic int unsigned afw_win_len(input int unsigned frames,
                                                input int unsigned pre_n,
                                                input int unsigned post_n,
                                                input int unsigned frame_len);
      return pre_n + frames * frame_len + post_n;
   endfunction

endpackage

// File: rtl/afw_delay_line.sv
module afw_delay_line #(
   parameter int W     = 12,
   parameter int DEPTH = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stage [DEPTH];

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stage[i] <= '0;
               else        stage[i] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) stage[i] <= '0;
               else        stage[i] <= stage[i-1];
            end
         end
      end
   endgenerate

   assign dout = stage[DEPTH-1];

endmodule

// File: rtl/afw_hdr_detect.sv
module afw_hdr_detect #(
   parameter int SAMPLE_W = 12,
   parameter int HDR_ONES = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_search,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] thresh,
   output logic                hit
);

   localparam int RUN_W = $clog2(HDR_ONES + 1);

   logic [RUN_W-1:0] run_q;
   logic             is_one;

   assign is_one = (sample > thresh);
   assign hit    = in_search && is_one && (run_q == RUN_W'(HDR_ONES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)          run_q <= '0;
      else if (!in_search) run_q <= '0;
      else if (is_one)     run_q <= (run_q == RUN_W'(HDR_ONES)) ? run_q : run_q + 1'b1;
      else                 run_q <= '0;
   end

endmodule

// File: rtl/afw_sat_counter.sv
module afw_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n)                    count <= '0;
      else if (inc && (count != '1)) count <= count + 1'b1;
   end

endmodule

// File: rtl/afw_window_seq.sv
module afw_window_seq
   import afw_pkg::*;
#(
   parameter int SAMPLE_W   = 12,
   parameter int SLOT_W     = 16,
   parameter int ADDR_W     = 9,
   parameter int FRM_W      = 2,
   parameter int TO_W       = 8,
   parameter int PRE_N      = 10,
   parameter int POST_N     = 10,
   parameter int FRAME_LEN  = 140,
   parameter int MAX_FRAMES = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig,
   input  logic                hit,
   input  logic [FRM_W-1:0]    frames_cfg,
   input  logic [TO_W-1:0]     timeout_cfg,
   input  logic [SAMPLE_W-1:0] tap,
   output logic                in_search,
   output logic                busy,
   output logic                wr_en,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [SLOT_W-1:0]   wr_data,
   output logic                event_done,
   output logic                sync_err
);

   afw_state_e        state_q;
   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] last_q;
   logic [ADDR_W-1:0] last_calc;
   logic [TO_W-1:0]   srch_q;
   logic              pad_q;
   logic              tmo;
   logic [SLOT_W-1:0] slot;
   logic [31:0]       fr_i;

   generate
      if (SLOT_W > SAMPLE_W) begin : g_zext
         assign slot = {{(SLOT_W-SAMPLE_W){1'b0}}, tap};
      end else begin : g_flat
         assign slot = tap;
      end
   endgenerate

   always_comb begin
      fr_i = 32'(frames_cfg);
      if (fr_i == 32'd0)                   fr_i = 32'd1;
      else if (fr_i > 32'(MAX_FRAMES))     fr_i = 32'(MAX_FRAMES);
      last_calc = ADDR_W'(afw_win_len(fr_i, PRE_N, POST_N, FRAME_LEN) - 1);
   end

   assign in_search = (state_q == ST_SEARCH);
   assign busy      = (state_q != ST_IDLE);
   assign tmo       = ({1'b0, srch_q} + 1'b1) >= {1'b0, timeout_cfg};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         last_q     <= '0;
         srch_q     <= '0;
         pad_q      <= 1'b0;
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         event_done <= 1'b0;
         sync_err   <= 1'b0;
      end else begin
         wr_en      <= 1'b0;
         event_done <= wr_en && (wr_addr == last_q);
         unique case (state_q)
            ST_IDLE: begin
               if (trig) begin
                  state_q <= ST_SEARCH;
                  srch_q  <= '0;
                  last_q  <= last_calc;
               end
            end
            ST_SEARCH: begin
               if (hit) begin
                  wr_en   <= 1'b1;
                  wr_addr <= '0;
                  wr_data <= slot;
                  pad_q   <= 1'b0;
                  cnt_q   <= ADDR_W'(1);
                  state_q <= ST_CAPT;
               end else if (tmo) begin
                  wr_en    <= 1'b1;
                  wr_addr  <= '0;
                  wr_data  <= '0;
                  pad_q    <= 1'b1;
                  sync_err <= 1'b1;
                  cnt_q    <= ADDR_W'(1);
                  state_q  <= ST_CAPT;
               end else begin
                  srch_q <= srch_q + 1'b1;
               end
            end
            ST_CAPT: begin
               wr_en   <= 1'b1;
               wr_addr <= cnt_q;
               wr_data <= pad_q ? '0 : slot;
               cnt_q   <= cnt_q + 1'b1;
               if (cnt_q == last_q) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/frame_window_capture.sv
module frame_window_capture
   import afw_pkg::*;
#(
   parameter int SAMPLE_W   = 12,
   parameter int SLOT_W     = 16,
   parameter int HDR_LEN    = 12,
   parameter int CHAN_N     = 128,
   parameter int PRE_N      = 10,
   parameter int POST_N     = 10,
   parameter int MAX_FRAMES = 3,
   parameter int FRM_W      = 2,
   parameter int HDR_ONES   = 3,
   parameter int TO_W       = 8,
   parameter int OVR_W      = 8,
   localparam int FRAME_LEN = HDR_LEN + CHAN_N,
   localparam int WIN_MAX   = PRE_N + MAX_FRAMES * FRAME_LEN + POST_N,
   localparam int ADDR_W    = $clog2(WIN_MAX)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                trig,
   input  logic [FRM_W-1:0]    frames_cfg,
   input  logic [SAMPLE_W-1:0] thresh,
   input  logic [TO_W-1:0]     timeout_cfg,
   output logic                wr_en,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [SLOT_W-1:0]   wr_data,
   output logic                event_done,
   output logic                sync_err,
   output logic [OVR_W-1:0]    ovr_cnt
);

   localparam int DLY = PRE_N + HDR_ONES - 1;

   generate
      if (SLOT_W < SAMPLE_W) begin : g_bad_slot
         $error("slot narrower than sample");
      end
      if (HDR_ONES < 1 || HDR_ONES > HDR_LEN) begin : g_bad_ones
         $error("header check length out of range");
      end
      if (MAX_FRAMES < 1) begin : g_bad_frames
         $error("at least one frame per event");
      end
      if (DLY < 1) begin : g_bad_dly
         $error("delay line needs one stage");
      end
   endgenerate

   logic [SAMPLE_W-1:0] tap;
   logic                hit;
   logic                in_search;
   logic                busy;

   afw_delay_line #(.W(SAMPLE_W), .DEPTH(DLY)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sample_in),
      .dout (tap)
   );

   afw_hdr_detect #(.SAMPLE_W(SAMPLE_W), .HDR_ONES(HDR_ONES)) u_hdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_search(in_search),
      .sample   (sample_in),
      .thresh   (thresh),
      .hit      (hit)
   );

   afw_window_seq #(
      .SAMPLE_W  (SAMPLE_W),
      .SLOT_W    (SLOT_W),
      .ADDR_W    (ADDR_W),
      .FRM_W     (FRM_W),
      .TO_W      (TO_W),
      .PRE_N     (PRE_N),
      .POST_N    (POST_N),
      .FRAME_LEN (FRAME_LEN),
      .MAX_FRAMES(MAX_FRAMES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig),
      .hit        (hit),
      .frames_cfg (frames_cfg),
      .timeout_cfg(timeout_cfg),
      .tap        (tap),
      .in_search  (in_search),
      .busy       (busy),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .event_done (event_done),
      .sync_err   (sync_err)
   );

   afw_sat_counter #(.W(OVR_W)) u_ovr (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (trig && busy),
      .count(ovr_cnt)
   );

endmodule

// File: rtl/frame_window_capture_chk.sv
module frame_window_capture_chk #(
   parameter int SAMPLE_W = 12,
   parameter int SLOT_W   = 16,
   parameter int ADDR_W   = 9,
   parameter int OVR_W    = 8,
   parameter int WIN_MAX  = 440
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [SLOT_W-1:0] wr_data,
   input logic              event_done,
   input logic              sync_err,
   input logic [OVR_W-1:0]  ovr_cnt
);

   // R1: a nonzero address only follows the previous address written the cycle before
   assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0) |-> ($past(wr_en) && wr_addr == $past(wr_addr) + 1'b1));

   // R1: the address never leaves the largest window
   assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(wr_addr) < 32'(WIN_MAX)));

   // R3: the slot bits above the sample stay clear
   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_data >> SAMPLE_W) == '0));

   // R6: the error flag does not clear by itself
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_err) |-> sync_err);

   // R7: the overrun count never decreases
   assert_ovr_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_cnt >= $past(ovr_cnt));

   // R8: the done pulse follows a write and lasts one cycle
   assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      event_done |-> ($past(wr_en) && !wr_en));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      event_done |=> !event_done);

endmodule

bind frame_window_capture frame_window_capture_chk #(
   .SAMPLE_W(SAMPLE_W),
   .SLOT_W  (SLOT_W),
   .ADDR_W  (ADDR_W),
   .OVR_W   (OVR_W),
   .WIN_MAX (WIN_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .event_done(event_done),
   .sync_err  (sync_err),
   .ovr_cnt   (ovr_cnt)
);

// File: tb/tb_frame_window_capture.sv
`timescale 1ns/100ps
module tb_frame_window_capture;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] sample_in;
   logic        trig;
   logic [1:0]  frames_cfg;
   logic [11:0] thresh;
   logic [7:0]  timeout_cfg;
   logic        wr_en;
   logic [8:0]  wr_addr;
   logic [15:0] wr_data;
   logic        event_done;
   logic        sync_err;
   logic [7:0]  ovr_cnt;

   always #2.5 clk = ~clk;

   frame_window_capture dut (
      .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .trig(trig),
      .frames_cfg(frames_cfg), .thresh(thresh), .timeout_cfg(timeout_cfg),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .event_done(event_done), .sync_err(sync_err), .ovr_cnt(ovr_cnt)
   );

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   logic [11:0] ring [0:1023];
   int hs = 1 << 30;
   int mode = 0;
   int trig_at = -1, hold_lo = -1, hold_hi = -1;
   int pl0 = -1, pl1 = -1, pl2 = -1;
   bit pad_exp = 0;
   int base = 0;
   int nw, addr_bad, mism, ndone, done_cyc, first_cyc, mis_act, mis_exp;
   bit [11:0] hdr_bits = 12'b111010010110;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] hi_val(input int n);
      return 12'(3000 + n % 5);
   endfunction

   function automatic logic [11:0] gen(input int n);
      if (mode == 1 && n == hs - 1) return thresh;
      if (mode == 2 && (n == hs - 3 || n == hs - 2)) return hi_val(n);
      if (mode == 2 && n == hs - 1) return 12'd300;
      if (n < hs) return 12'(100 + n % 7);
      if (n < hs + 12) return hdr_bits[11 - (n - hs)] ? hi_val(n) : 12'd300;
      return 12'((n * 37 + 5) & 32'hFFF);
   endfunction

   task automatic tick();
      logic [15:0] expd;
      @(negedge clk);
      if (rst_n) begin
         if (wr_en) begin
            if (nw == 0) first_cyc = cyc;
            if (int'(wr_addr) != nw) addr_bad++;
            expd = pad_exp ? 16'h0 : {4'h0, ring[(base + nw) & 1023]};
            if (wr_data != expd) begin
               if (mism == 0) begin mis_act = int'(wr_data); mis_exp = int'(expd); end
               mism++;
            end
            nw++;
         end
         if (event_done) begin
            ndone++;
            done_cyc = cyc;
         end
      end
      sample_in = gen(cyc);
      ring[cyc & 1023] = sample_in;
      trig = (cyc == trig_at) || (cyc >= hold_lo && cyc <= hold_hi) ||
             (cyc == pl0) || (cyc == pl1) || (cyc == pl2);
      cyc++;
   endtask

   task automatic run_event(input int fr, input int d, input int t_cfg, input int md,
                            input bit exp_tmo, input bit exp_err, input int exp_ovr,
                            input int o0, input int o1, input int o2, input int hold);
      int ct, win, f, nf;
      nf = (fr == 0) ? 1 : ((fr > 3) ? 3 : fr);
      win = 10 + nf * 140 + 10;
      frames_cfg = 2'(fr);
      timeout_cfg = 8'(t_cfg);
      ct = cyc + 15;
      mode = md;
      hs = ct + 1 + d;
      trig_at = ct;
      pl0 = (o0 < 0) ? -1 : ct + o0;
      pl1 = (o1 < 0) ? -1 : ct + o1;
      pl2 = (o2 < 0) ? -1 : ct + o2;
      hold_lo = (hold > 0) ? ct + 1 : -1;
      hold_hi = (hold > 0) ? ct + hold : -1;
      f = exp_tmo ? ct + t_cfg + 1 : hs + 3;
      pad_exp = exp_tmo;
      base = f - 13;
      nw = 0; addr_bad = 0; mism = 0; ndone = 0; done_cyc = -1; first_cyc = -1;
      mis_act = 0; mis_exp = 0;
      while (cyc <= f + win + 3) tick();
      trig_at = -1; hold_lo = -1; hold_hi = -1; pl0 = -1; pl1 = -1; pl2 = -1;
      if (exp_tmo)
         check(first_cyc == f, "R5", "timeout first write cycle", first_cyc, f);
      else
         check(first_cyc == f, "R4", "header first write cycle", first_cyc, f);
      check(nw == win, "R1", "write count", nw, win);
      check(addr_bad == 0, "R1", "address order errors", addr_bad, 0);
      if (exp_tmo)
         check(mism == 0, "R5", "padded data", mis_act, mis_exp);
      else
         check(mism == 0, "R3", "window data", mis_act, mis_exp);
      check(ndone == 1 && done_cyc == f + win, "R8", "done cycle", done_cyc, f + win);
      check(sync_err == exp_err, "R6", "sync error flag", int'(sync_err), int'(exp_err));
      check(int'(ovr_cnt) == exp_ovr, "R7", "overrun count", int'(ovr_cnt), exp_ovr);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      sample_in = '0;
      trig = 1'b0;
      frames_cfg = 2'd1;
      thresh = 12'd2000;
      timeout_cfg = 8'd60;
      repeat (5) tick();
      rst_n = 1'b1;
      repeat (3) tick();
      // R9: reset state at the ports
      check(wr_en == 1'b0, "R9", "wr_en after reset", int'(wr_en), 0);
      check(event_done == 1'b0, "R9", "event_done after reset", int'(event_done), 0);
      check(sync_err == 1'b0, "R9", "sync_err after reset", int'(sync_err), 0);
      check(ovr_cnt == 8'd0, "R9", "ovr_cnt after reset", int'(ovr_cnt), 0);
      repeat (20) tick();

      // R1 R2 R3 R4: sweep header offset and frame count, including clamp of 0
      for (int d = 0; d < 8; d++) run_event(d % 4, d, 60, 0, 0, 0, 0, -1, -1, -1, 0);
      // R2: a sample equal to the threshold is a zero
      run_event(1, 4, 60, 1, 0, 0, 0, -1, -1, -1, 0);
      // R2: two ones then a zero do not start a header
      run_event(1, 6, 60, 2, 0, 0, 0, -1, -1, -1, 0);
      // R5: header completing on the last allowed search cycle is accepted
      run_event(1, 10, 13, 0, 0, 0, 0, -1, -1, -1, 0);
      // R7: triggers during search and capture are ignored and counted
      run_event(1, 3, 60, 0, 0, 0, 3, 2, 20, 100, 0);
      // R5 R6: header one cycle too late gives a padded window and the error flag
      run_event(1, 10, 12, 0, 1, 1, 3, -1, -1, -1, 0);
      // R6: flag stays set through a normal event
      run_event(2, 1, 40, 0, 0, 1, 3, -1, -1, -1, 0);
      // R7: counter stops at its top value
      run_event(3, 0, 60, 0, 0, 1, 255, -1, -1, -1, 300);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule